// File: doc/BRIEF.md
# Modem Handshake Controller

This block runs the modem-side handshake of a synchronous serial link. It raises request-to-send by itself once the transmit queue presents a message-start entry at its head, and drops it when the queue runs dry or the link is initialised. Transmission is allowed only while the modem reports clear-to-send and is ready. During half-duplex operation the receive clock is held off for as long as request-to-send is up, so the receiver does not hear the local transmitter.

The host sees one 8-bit status byte. Two of its bits are writable: the half-duplex select and data-terminal-ready. The other six report live line states and two board switches. Two strap inputs adapt the block to modems that need a steady signal. One holds modem-ready on regardless of data-set-ready. The other holds request-to-send on. The three asynchronous modem lines pass through a synchroniser chain before any logic uses them.

Top module: `mdm_hshk_ctrl`

## Requirements
- R1: When the queue head carries a message-start flag (`txq_som_head`=1) and the queue is not empty, the automatic request-to-send rises at the next clock edge and stays up while the queue holds data.
- R2: The automatic request-to-send falls at the next clock edge after `txq_empty`=1 is seen, or after `link_init`=1.
- R3: With `strap_rts_on`=1, `rts` is 1 whatever the queue state.
- R4: `tx_en` is the AND of synchronised clear-to-send and modem-ready. A change on a modem line reaches the outputs after exactly SYNC_STAGES clock edges (2 by default).
- R5: With `strap_mrdy_on`=1, modem-ready is 1 whatever `dsr_in` is. Otherwise it follows synchronised `dsr_in`.
- R6: While the half-duplex bit and `rts` are both 1, `rx_clk_en` is 0. Otherwise it is 1.
- R7: Data-terminal-ready is 1 after reset and after `link_init`. Only a host write with bit 6 = 0 clears it, and `link_init` wins over a simultaneous write.
- R8: The half-duplex bit is loaded from bit 4 of a host write and is cleared by reset or `link_init`.
- R9: Status byte layout, bit 0 upward: secure switch, type switch, clear-to-send, modem-ready, half-duplex, request-to-send, data-terminal-ready, ring.
- R10: A host write has no effect on the read-only status bits 0, 1, 2, 3, 5 and 7.
- R11: After reset, `rts`=0, `dtr`=1, `tx_en`=0, `rx_clk_en`=1 and the half-duplex bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_in | input | 1 | Clear-to-send from modem (asynchronous) |
| dsr_in | input | 1 | Data-set-ready from modem (asynchronous) |
| ring_in | input | 1 | Ring indicator from modem (asynchronous) |
| txq_som_head | input | 1 | Head entry of transmit queue carries message-start flag |
| txq_empty | input | 1 | Transmit queue holds no data |
| link_init | input | 1 | Synchronous link initialisation pulse |
| host_wr | input | 1 | Host write strobe for status byte |
| host_wdata | input | 8 | Host write data |
| strap_mrdy_on | input | 1 | Strap: hold modem-ready on |
| strap_rts_on | input | 1 | Strap: hold request-to-send on |
| sw_secure | input | 1 | Board switch reported in status bit 0 |
| sw_type | input | 1 | Board switch reported in status bit 1 |
| rts | output | 1 | Request-to-send to modem |
| dtr | output | 1 | Data-terminal-ready to modem |
| tx_en | output | 1 | Transmitter enable |
| rx_clk_en | output | 1 | Receive clock gate, 1 lets the clock through |
| stat_rdata | output | 8 | Status byte readback |

## Verification
The bench targets the synchroniser latency. A design with one stage too few or too many would raise `tx_en` one edge early or late, and the bench samples on both sides of the expected edge. It writes all ones and then all zeros to the status byte. A design that lets the write reach read-only bits would show a spurious clear-to-send, request-to-send or ring. It drives `link_init` together with a host write that clears data-terminal-ready, where a wrong priority would leave `dtr` low. It also checks that the receive clock gate reopens as soon as either request-to-send or half-duplex drops. A design that latched the inhibit would keep the receiver blind.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int STAT_W   = 8;
   localparam int B_SECURE = 0;
   localparam int B_TYPE   = 1;
   localparam int B_CTS    = 2;
   localparam int B_MRDY   = 3;
   localparam int B_HDX    = 4;
   localparam int B_RTS    = 5;
   localparam int B_DTR    = 6;
   localparam int B_RING   = 7;
   localparam logic [STAT_W-1:0] WR_MASK  = (STAT_W'(1) << B_HDX) | (STAT_W'(1) << B_DTR);
   localparam logic [STAT_W-1:0] INIT_VAL = (STAT_W'(1) << B_DTR);
   typedef enum logic {RTS_OFF = 1'b0, RTS_ON = 1'b1} rts_st_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("mdm_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stg[i] <= '0;
         else if (i == 0)
            stg[i] <= d;
         else
            stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_rts_ctl.sv
module mdm_rts_ctl
   import mdm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic som_head,
   input  logic q_empty,
   output logic rts_auto
);
   rts_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (init)
         st_d = RTS_OFF;
      else if (q_empty)
         st_d = RTS_OFF;
      else if (som_head)
         st_d = RTS_ON;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= RTS_OFF;
      else        st_q <= st_d;
   end

   assign rts_auto = (st_q == RTS_ON);

   // R1: message-start at a non-empty head raises request-to-send
   p_rts_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && som_head && !q_empty) |=> rts_auto);
   // R2: empty queue or init drops it
   p_rts_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (init || q_empty) |=> !rts_auto);
   // R1: holds while data remains and no init
   p_rts_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_auto && !init && !q_empty) |=> rts_auto);
endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
   import mdm_pkg::*;
#(
   parameter logic [STAT_W-1:0] WMASK = WR_MASK,
   parameter logic [STAT_W-1:0] IVAL  = INIT_VAL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              wr,
   input  logic [STAT_W-1:0] wdata,
   input  logic [STAT_W-1:0] live,
   output logic [STAT_W-1:0] rdata,
   output logic              hdx,
   output logic              dtr
);
   logic [STAT_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= IVAL & WMASK;
      else if (init)
         held_q <= IVAL & WMASK;
      else if (wr)
         held_q <= wdata & WMASK;
   end

   assign rdata = (live & ~WMASK) | (held_q & WMASK);
   assign hdx   = held_q[B_HDX];
   assign dtr   = held_q[B_DTR];

   // R7: init forces DTR on
   p_dtr_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> dtr);
   // R7: without write or init DTR keeps its value
   p_dtr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !wr) |=> $stable(dtr));
   // R8: init clears half-duplex
   p_hdx_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> !hdx);
endmodule

// File: rtl/mdm_hshk_ctrl.sv
module mdm_hshk_ctrl
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cts_in,
   input  logic              dsr_in,
   input  logic              ring_in,
   input  logic              txq_som_head,
   input  logic              txq_empty,
   input  logic              link_init,
   input  logic              host_wr,
   input  logic [STAT_W-1:0] host_wdata,
   input  logic              strap_mrdy_on,
   input  logic              strap_rts_on,
   input  logic              sw_secure,
   input  logic              sw_type,
   output logic              rts,
   output logic              dtr,
   output logic              tx_en,
   output logic              rx_clk_en,
   output logic [STAT_W-1:0] stat_rdata
);
   localparam int NLINES = 3;

   if (STAT_W != 8) begin : g_bad_width
      $error("mdm_hshk_ctrl: status byte must be 8 bits");
   end

   logic [NLINES-1:0] lines_a, lines_s;
   logic cts_s, dsr_s, ring_s, mrdy, rts_auto, hdx;
   logic [STAT_W-1:0] live;

   assign lines_a = {ring_in, dsr_in, cts_in};

   mdm_sync #(.STAGES(SYNC_STAGES), .WIDTH(NLINES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(lines_a), .q(lines_s));

   assign cts_s  = lines_s[0];
   assign dsr_s  = lines_s[1];
   assign ring_s = lines_s[2];

   mdm_rts_ctl u_rts (
      .clk(clk), .rst_n(rst_n), .init(link_init),
      .som_head(txq_som_head), .q_empty(txq_empty), .rts_auto(rts_auto));

   assign mrdy      = strap_mrdy_on | dsr_s;
   assign rts       = strap_rts_on  | rts_auto;
   assign tx_en     = cts_s & mrdy;
   assign rx_clk_en = ~(hdx & rts);

   always_comb begin
      live           = '0;
      live[B_SECURE] = sw_secure;
      live[B_TYPE]   = sw_type;
      live[B_CTS]    = cts_s;
      live[B_MRDY]   = mrdy;
      live[B_RTS]    = rts;
      live[B_RING]   = ring_s;
   end

   mdm_stat_reg u_stat (
      .clk(clk), .rst_n(rst_n), .init(link_init), .wr(host_wr),
      .wdata(host_wdata), .live(live), .rdata(stat_rdata),
      .hdx(hdx), .dtr(dtr));

   // R6: receive clock blocked while readback shows half-duplex and RTS
   p_rx_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rdata[B_HDX] && stat_rdata[B_RTS]) |-> !rx_clk_en);
   // R3: strap keeps RTS up
   p_rts_strap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      strap_rts_on |-> rts);
   // R4: transmit enable only with clear-to-send seen in readback
   p_txen_cts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> (stat_rdata[B_CTS] && stat_rdata[B_MRDY]));
   // R10: a write never alters the type switch bit in the readback
   p_ro_type_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && $stable(sw_type)) |=> (stat_rdata[B_TYPE] == sw_type));
endmodule

// File: tb/mdm_hshk_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdm_hshk_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cts_in = 0, dsr_in = 0, ring_in = 0;
   logic txq_som_head = 0, txq_empty = 1, link_init = 0, host_wr = 0;
   logic [7:0] host_wdata = 8'h00;
   logic strap_mrdy_on = 0, strap_rts_on = 0, sw_secure = 0, sw_type = 1;
   logic rts, dtr, tx_en, rx_clk_en;
   logic [7:0] stat_rdata;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mdm_hshk_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .dsr_in(dsr_in), .ring_in(ring_in),
      .txq_som_head(txq_som_head), .txq_empty(txq_empty), .link_init(link_init),
      .host_wr(host_wr), .host_wdata(host_wdata), .strap_mrdy_on(strap_mrdy_on),
      .strap_rts_on(strap_rts_on), .sw_secure(sw_secure), .sw_type(sw_type),
      .rts(rts), .dtr(dtr), .tx_en(tx_en), .rx_clk_en(rx_clk_en), .stat_rdata(stat_rdata));

   // {cts, dsr, strap_mrdy, exp_tx_en, exp_mrdy}; tx_en = cts & (dsr | strap)
   localparam logic [4:0] VEC [8] = '{
      5'b000_0_0, 5'b001_0_1, 5'b010_0_1, 5'b011_0_1,
      5'b100_0_0, 5'b101_1_1, 5'b110_1_1, 5'b111_1_1};

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic hwrite(input logic [7:0] v);
      host_wr = 1; host_wdata = v; cyc(1); host_wr = 0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      cyc(3); rst_n = 1; cyc(1);
      // R11 reset state, R9 layout: type switch bit1, dtr bit6
      chk("R11 rts", rts, 0); chk("R11 dtr", dtr, 1);
      chk("R11 tx_en", tx_en, 0); chk("R11 rx_clk_en", rx_clk_en, 1);
      chk("R9 reset readback", stat_rdata, 8'h42);

      // R4 R5: table walk
      for (int k = 0; k < 8; k++) begin
         {cts_in, dsr_in, strap_mrdy_on} = VEC[k][4:2];
         cyc(3);
         chk("R4 tx_en table", tx_en, VEC[k][1]);
         chk("R5 mrdy bit3", stat_rdata[3], VEC[k][0]);
         chk("R9 cts bit2", stat_rdata[2], VEC[k][4]);
      end
      cts_in = 0; dsr_in = 0; strap_mrdy_on = 0; cyc(3);

      // R4 latency: two edges exactly
      cts_in = 1; dsr_in = 1; cyc(1);
      chk("R4 after one edge", tx_en, 0);
      cyc(1);
      chk("R4 after two edges", tx_en, 1);
      cts_in = 0; dsr_in = 0; cyc(3);

      // R10: write all ones, only hdx/dtr held
      hwrite(8'hFF);
      chk("R10 readback after FF", stat_rdata, 8'h52);
      chk("R10 rts unchanged", rts, 0);
      hwrite(8'h00);
      chk("R7 dtr cleared by write", dtr, 0);
      chk("R10 readback after 00", stat_rdata, 8'h02);

      // R7 R8: init vs write, init wins
      hwrite(8'h10);
      chk("R8 hdx set", stat_rdata[4], 1);
      link_init = 1; host_wr = 1; host_wdata = 8'h10; cyc(1);
      link_init = 0; host_wr = 0;
      chk("R7 init wins dtr", dtr, 1);
      chk("R8 init clears hdx", stat_rdata[4], 0);

      // R1 R2: automatic RTS
      txq_empty = 0; txq_som_head = 1; cyc(1);
      chk("R1 rts rises", rts, 1);
      chk("R9 rts bit5", stat_rdata[5], 1);
      txq_som_head = 0; cyc(2);
      chk("R1 rts holds", rts, 1);
      txq_empty = 1; cyc(1);
      chk("R2 rts drops on empty", rts, 0);
      txq_empty = 0; txq_som_head = 1; cyc(1);
      txq_som_head = 0; link_init = 1; cyc(1); link_init = 0;
      chk("R2 rts drops on init", rts, 0);
      cyc(1);
      chk("R2 stays low without new start", rts, 0);
      txq_empty = 1;

      // R6: half-duplex gating
      hwrite(8'h50);
      chk("R6 hdx only, gate open", rx_clk_en, 1);
      txq_empty = 0; txq_som_head = 1; cyc(1); txq_som_head = 0;
      chk("R6 hdx and rts, gate shut", rx_clk_en, 0);
      hwrite(8'h40);
      chk("R6 hdx dropped, gate open", rx_clk_en, 1);
      hwrite(8'h50);
      chk("R6 gate shut again", rx_clk_en, 0);
      txq_empty = 1; cyc(1);
      chk("R6 rts dropped, gate open", rx_clk_en, 1);

      // R3: strap holds rts
      strap_rts_on = 1; cyc(1);
      chk("R3 forced rts", rts, 1);
      chk("R6 forced rts with hdx", rx_clk_en, 0);
      strap_rts_on = 0; hwrite(8'h40);

      // R9: ring and secure bits
      ring_in = 1; sw_secure = 1; cyc(3);
      chk("R9 ring and secure", stat_rdata, 8'hC3);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule